// File: doc/BRIEF.md
# Temperature-Indexed Fan Setting Table

This block turns a set of temperature readings into a single fan command. It keeps a small table of up to eight ascending steps. Each step holds one fan value and one trip level for every temperature channel. Whenever a fresh set of readings arrives, the block picks the highest step that any channel has reached and drives that step's value out. The output moves down to a lower step only once the readings have cooled below the current step's trip level by a shared hysteresis margin.

A configuration field selects how the table values are read by the downstream logic. They can be PWM duty values for a direct drive, or tachometer targets for a speed loop. The only difference this makes inside the block is the value sent out when no step is active.

A lock bit hands control to the table and freezes its contents. While the lock is clear, the output follows a manually written value. All programming uses a single-cycle write port: address and data, qualified by a write enable.

Top module: `fan_curve_lut`

## Requirements
- R1: After reset, every trip level is 8'hFF, every step value is 0, the hysteresis is 0, the manual value is 0, the configuration is 0 (unlocked, tachometer-target mode) and the active level is 0, so `fan_out` is 0.
- R2: While unlocked (configuration bit 1 = 0), `fan_out` equals the last manual value written to address 42, `step_lvl` holds 0 from the second cycle on, and sample strobes have no effect.
- R3: Step k (levels 1..8 at step index k-1) triggers when any channel's reading is greater than or equal to that step's trip level for that channel. Channel c's reading sits in `smp_temps[8c+7:8c]`. The trip level for step s, channel c is written at address 4*s+c. A trip level of 8'hFF never triggers, even for a reading of 8'hFF.
- R4: When several channels trigger different steps, the highest triggered step becomes the level.
- R5: On a sample strobe while locked, a highest triggered step above the current level is taken directly in that cycle. `step_lvl` and `fan_out` show it after that clock edge.
- R6: On a sample strobe while locked, a step at or below the current level stays eligible if any channel reading is at or above that step's trip level minus the hysteresis. The hysteresis is written at address 40, and the subtraction floors at 0. A disabled (8'hFF) trip level never holds. If the current step is not held, the level falls to the highest lower step that is held, or to 0.
- R7: The level changes only on a sample strobe while locked, or through R10.
- R8: While locked, `fan_out` is the value of the active step (step s written at address 32+s). At level 0 it is the off value: 8'h00 when configuration bit 0 = 1 (PWM mode) and 8'hFF when bit 0 = 0 (tachometer mode). The configuration is written at address 41.
- R9: While locked, writes to trip levels, step values and the hysteresis are ignored. Writes to the configuration and the manual value always take effect.
- R10: One cycle after the lock clears, the level is 0, so a later re-lock starts from the off value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 6 | Register address |
| wr_data | input | 8 | Register write data |
| smp_valid | input | 1 | One-cycle strobe marking a fresh set of readings |
| smp_temps | input | 32 | Channel readings, channel 0 in the low byte |
| fan_out | output | 8 | Selected fan command |
| step_lvl | output | 4 | Active level, 0 = no step |

## Verification
A configuration write and a sample strobe can land in the same cycle. The strobe is judged against the lock state from before that edge. The bench asserts the lock and strobes hot readings in one cycle and expects the off value, with the step taken only at the following strobe. It also clears the lock with a level active and expects the manual value at once and level 0 one cycle later. A reference model in the bench, updated edge by edge, predicts both outputs. This covers the directed cases and a long random run that mixes strobes with writes to every address, the lock bit included.

// File: rtl/fcl_pkg.sv
`timescale 1ns/1ps
package fcl_pkg;
  // configuration register layout: bit1 = table lock, bit0 = PWM mode
  typedef struct packed {
    logic lock;
    logic pwm_mode;
  } fcl_cfg_t;
endpackage

// File: rtl/fcl_regs.sv
`timescale 1ns/1ps
module fcl_regs
  import fcl_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_STEP = 8,
  parameter int DW       = 8,
  parameter int AW       = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  output fcl_cfg_t                   cfg_q,
  output logic [NUM_STEP*NUM_CH*DW-1:0] thr_flat,
  output logic [NUM_STEP*DW-1:0]     set_flat,
  output logic [DW-1:0]              hyst_q,
  output logic [DW-1:0]              manual_q
);
  localparam int THR_CNT   = NUM_STEP * NUM_CH;
  localparam int SET_BASE  = THR_CNT;
  localparam int HYST_ADDR = SET_BASE + NUM_STEP;
  localparam int CFG_ADDR  = HYST_ADDR + 1;
  localparam int MAN_ADDR  = CFG_ADDR + 1;

  // table is writable only while unlocked
  logic tbl_we;
  assign tbl_we = wr_en && !cfg_q.lock;

  genvar gi;
  generate
    for (gi = 0; gi < THR_CNT; gi++) begin : g_thr
      logic [DW-1:0] thr_q;
      logic          thr_en;
      assign thr_en = tbl_we && (wr_addr == AW'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr_q <= '1;
        else if (thr_en) thr_q <= wr_data;
      end
      assign thr_flat[gi*DW +: DW] = thr_q;
    end
    for (gi = 0; gi < NUM_STEP; gi++) begin : g_set
      logic [DW-1:0] set_q;
      logic          set_en;
      assign set_en = tbl_we && (wr_addr == AW'(SET_BASE + gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      set_q <= '0;
        else if (set_en) set_q <= wr_data;
      end
      assign set_flat[gi*DW +: DW] = set_q;
    end
  endgenerate

  logic hyst_en, cfg_en, man_en;
  assign hyst_en = tbl_we && (wr_addr == AW'(HYST_ADDR));
  assign cfg_en  = wr_en  && (wr_addr == AW'(CFG_ADDR));
  assign man_en  = wr_en  && (wr_addr == AW'(MAN_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hyst_q   <= '0;
      cfg_q    <= '0;
      manual_q <= '0;
    end else begin
      if (hyst_en) hyst_q   <= wr_data;
      if (cfg_en)  cfg_q    <= fcl_cfg_t'(wr_data[1:0]);
      if (man_en)  manual_q <= wr_data;
    end
  end

  // R9: table contents frozen across any cycle that starts locked
  p_table_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> ($stable(thr_flat) && $stable(set_flat) && $stable(hyst_q)));
endmodule

// File: rtl/fcl_step_eval.sv
`timescale 1ns/1ps
module fcl_step_eval #(
  parameter int NUM_CH   = 4,
  parameter int NUM_STEP = 8,
  parameter int DW       = 8
) (
  input  logic [NUM_CH*DW-1:0]          temps,
  input  logic [NUM_STEP*NUM_CH*DW-1:0] thr_flat,
  input  logic [DW-1:0]                 hyst,
  output logic [NUM_STEP-1:0]           trig_vec,
  output logic [NUM_STEP-1:0]           hold_vec
);
  genvar gs, gc;
  generate
    for (gs = 0; gs < NUM_STEP; gs++) begin : g_step
      logic [NUM_CH-1:0] trig_c, hold_c;
      for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
        logic [DW-1:0] thr, rd, floor_v;
        logic          en;
        assign thr     = thr_flat[(gs*NUM_CH+gc)*DW +: DW];
        assign rd      = temps[gc*DW +: DW];
        assign en      = (thr != '1);
        assign floor_v = (thr >= hyst) ? (thr - hyst) : '0;
        assign trig_c[gc] = en && (rd >= thr);
        assign hold_c[gc] = en && (rd >= floor_v);
      end
      assign trig_vec[gs] = |trig_c;
      assign hold_vec[gs] = |hold_c;
    end
  endgenerate
endmodule

// File: rtl/fcl_level_ctrl.sv
`timescale 1ns/1ps
module fcl_level_ctrl
  import fcl_pkg::*;
#(
  parameter int NUM_STEP = 8,
  parameter int DW       = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp_valid,
  input  fcl_cfg_t                    cfg,
  input  logic [NUM_STEP-1:0]         trig_vec,
  input  logic [NUM_STEP-1:0]         hold_vec,
  input  logic [NUM_STEP*DW-1:0]      set_flat,
  input  logic [DW-1:0]               manual,
  output logic [$clog2(NUM_STEP+1)-1:0] lvl_q,
  output logic [DW-1:0]               fan_out
);
  localparam int LW = $clog2(NUM_STEP + 1);
  localparam int SB = (NUM_STEP > 1) ? $clog2(NUM_STEP) : 1;

  logic [LW-1:0] up_lvl, hold_lvl, lvl_d;
  logic [DW-1:0] set_sel;

  // next-state logic
  always_comb begin
    up_lvl   = '0;
    hold_lvl = '0;
    for (int k = 0; k < NUM_STEP; k++) begin
      if (trig_vec[k]) up_lvl = LW'(k + 1);
      if (hold_vec[k] && (LW'(k) < lvl_q)) hold_lvl = LW'(k + 1);
    end
    lvl_d = lvl_q;
    if (!cfg.lock)      lvl_d = '0;
    else if (smp_valid) lvl_d = (up_lvl > lvl_q) ? up_lvl : hold_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  // output selection
  always_comb begin
    set_sel = '0;
    for (int k = 0; k < NUM_STEP; k++)
      if (lvl_q == LW'(k + 1)) set_sel = set_flat[k*DW +: DW];
    if (!cfg.lock)          fan_out = manual;
    else if (lvl_q == '0)   fan_out = cfg.pwm_mode ? '0 : '1;
    else                    fan_out = set_sel;
  end

  logic          cur_held;
  logic [SB-1:0] cur_idx;
  assign cur_idx  = SB'(lvl_q - 1'b1);
  assign cur_held = (lvl_q != '0) && hold_vec[cur_idx];

  p_lvl_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(NUM_STEP));
  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.lock && !smp_valid) |=> $stable(lvl_q));
  p_top_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.lock && smp_valid && trig_vec[NUM_STEP-1]) |=> (lvl_q == LW'(NUM_STEP)));
  p_held_no_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.lock && smp_valid && cur_held) |=> (lvl_q >= $past(lvl_q)));
  p_unlock_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.lock |=> (lvl_q == '0));
endmodule

// File: rtl/fan_curve_lut.sv
`timescale 1ns/1ps
module fan_curve_lut
  import fcl_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_STEP = 8,
  parameter int DW       = 8,
  parameter int AW       = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [DW-1:0]                 wr_data,
  input  logic                          smp_valid,
  input  logic [NUM_CH*DW-1:0]          smp_temps,
  output logic [DW-1:0]                 fan_out,
  output logic [$clog2(NUM_STEP+1)-1:0] step_lvl
);
  fcl_cfg_t                      cfg_q;
  logic [NUM_STEP*NUM_CH*DW-1:0] thr_flat;
  logic [NUM_STEP*DW-1:0]        set_flat;
  logic [DW-1:0]                 hyst_q, manual_q;
  logic [NUM_STEP-1:0]           trig_vec, hold_vec;

  fcl_regs #(.NUM_CH(NUM_CH), .NUM_STEP(NUM_STEP), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_q(cfg_q), .thr_flat(thr_flat), .set_flat(set_flat),
    .hyst_q(hyst_q), .manual_q(manual_q)
  );

  fcl_step_eval #(.NUM_CH(NUM_CH), .NUM_STEP(NUM_STEP), .DW(DW)) u_eval (
    .temps(smp_temps), .thr_flat(thr_flat), .hyst(hyst_q),
    .trig_vec(trig_vec), .hold_vec(hold_vec)
  );

  fcl_level_ctrl #(.NUM_STEP(NUM_STEP), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cfg(cfg_q),
    .trig_vec(trig_vec), .hold_vec(hold_vec), .set_flat(set_flat),
    .manual(manual_q), .lvl_q(step_lvl), .fan_out(fan_out)
  );
endmodule

// File: tb/sim_fan_curve_lut.sv
`timescale 1ns/1ps
module sim_fan_curve_lut;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        smp_valid;
  logic [31:0] smp_temps;
  logic [7:0]  fan_out;
  logic [3:0]  step_lvl;

  always #4 clk = ~clk;

  fan_curve_lut u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .smp_valid(smp_valid), .smp_temps(smp_temps), .fan_out(fan_out), .step_lvl(step_lvl)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_thr[32];
  int m_set[8];
  int m_hyst, m_man, m_lvl;
  bit m_lock, m_mode;

  function automatic int rd(logic [31:0] t, int c);
    return int'(t[c*8 +: 8]);
  endfunction

  function automatic int m_eval(logic [31:0] t);
    int up = 0;
    int hold = 0;
    for (int k = 0; k < 8; k++)
      for (int c = 0; c < 4; c++)
        if (m_thr[k*4+c] != 255 && rd(t, c) >= m_thr[k*4+c]) up = k + 1;
    if (up > m_lvl) return up;
    for (int k = 0; k < m_lvl; k++)
      for (int c = 0; c < 4; c++) begin
        int lb = (m_thr[k*4+c] >= m_hyst) ? m_thr[k*4+c] - m_hyst : 0;
        if (m_thr[k*4+c] != 255 && rd(t, c) >= lb) hold = k + 1;
      end
    return hold;
  endfunction

  function automatic int m_out();
    if (!m_lock) return m_man;
    if (m_lvl == 0) return m_mode ? 0 : 255;
    return m_set[m_lvl-1];
  endfunction

  task automatic check(string tag);
    checks++;
    if (int'(fan_out) != m_out() || int'(step_lvl) != m_lvl) begin
      failures++;
      $display("FAIL %s: fan_out=%0h lvl=%0d expected fan_out=%0h lvl=%0d",
               tag, fan_out, step_lvl, m_out(), m_lvl);
    end
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic cyc(bit we, int addr, int data, bit smp, logic [31:0] t, string tag);
    wr_en = we; wr_addr = 6'(addr); wr_data = 8'(data);
    smp_valid = smp; smp_temps = t;
    @(posedge clk);
    if (!m_lock) m_lvl = 0;
    else if (smp) m_lvl = m_eval(t);
    if (we) begin
      if (addr < 32 && !m_lock)       m_thr[addr] = data;
      else if (addr >= 32 && addr < 40 && !m_lock) m_set[addr-32] = data;
      else if (addr == 40 && !m_lock) m_hyst = data;
      else if (addr == 41) begin m_mode = data[0]; m_lock = data[1]; end
      else if (addr == 42) m_man = data;
    end
    @(negedge clk);
    wr_en = 0; smp_valid = 0;
    check(tag);
  endtask

  task automatic wr(int addr, int data, string tag);
    cyc(1, addr, data, 0, smp_temps, tag);
  endtask

  task automatic smp(logic [31:0] t, string tag);
    cyc(0, 0, 0, 1, t, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 32; i++) m_thr[i] = 255;
    for (int i = 0; i < 8; i++) m_set[i] = 0;
    m_hyst = 0; m_man = 0; m_lvl = 0; m_lock = 0; m_mode = 0;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; smp_valid = 0; smp_temps = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset");

    // R2 manual output while unlocked, strobes ignored
    wr(42, 8'h5A, "R2 manual write");
    smp(32'hFFFF_FFFF, "R2 strobe ignored unlocked");

    // program table: ch0 trips 40+10k, ch1 trips only step 5 at 35
    for (int k = 0; k < 8; k++) begin
      wr(32 + k, 16 * (k + 1), "R9 table load");
      wr(k*4 + 0, 40 + 10*k, "R9 table load");
      if (k == 4) wr(k*4 + 1, 35, "R9 table load");
    end
    wr(40, 4, "R9 hyst load");
    wr(41, 3, "R8 lock pwm off value");

    smp({8'h0, 8'h0, 8'd0, 8'd60}, "R3 R5 equal trip rises to 3");
    smp({8'h0, 8'h0, 8'd0, 8'd59}, "R6 held within hysteresis");
    smp({8'h0, 8'h0, 8'd0, 8'd55}, "R6 drop to lower held step");
    smp({8'h0, 8'h0, 8'd40, 8'd60}, "R4 highest channel step wins");
    cyc(0, 0, 0, 0, 32'h0, "R7 no strobe no change");
    cyc(0, 0, 0, 0, 32'h0, "R7 no strobe no change");
    wr(36, 8'hEE, "R9 locked step write ignored");
    wr(0, 0, "R9 locked trip write ignored");
    smp(32'h0, "R9 R8 cold gives pwm off");
    smp({8'hFF, 8'hFF, 8'd0, 8'd0}, "R3 FF trip never triggers");
    smp({8'h0, 8'h0, 8'd0, 8'hFF}, "R5 top step from zero");

    // unlock with level active
    wr(41, 1, "R10 unlock shows manual");
    cyc(0, 0, 0, 0, 32'h0, "R10 level cleared");
    // lock write and strobe in the same cycle
    cyc(1, 41, 3, 1, {8'h0, 8'h0, 8'd0, 8'd60}, "R8 lock with strobe stays off");
    smp({8'h0, 8'h0, 8'd0, 8'd60}, "R5 next strobe takes step");
    wr(42, 8'h33, "R9 manual writable while locked");

    // tach mode and floored hysteresis
    wr(41, 0, "R2 unlock");
    wr(0, 2, "R6 trip near zero");
    wr(41, 2, "R8 lock tach off value");
    smp({8'h0, 8'h0, 8'd0, 8'd10}, "R3 low trip step 1");
    smp(32'h0, "R6 floored hysteresis holds");

    // random section
    wr(41, 0, "R2 unlock for random load");
    for (int i = 0; i < 32; i++)
      wr(i, (($urandom % 8) == 0) ? 255 : ($urandom % 256), "R9 random load");
    for (int i = 0; i < 8; i++) wr(32 + i, $urandom % 256, "R9 random load");
    wr(40, $urandom % 16, "R9 random load");
    wr(41, 2 + ($urandom % 2), "R8 random lock");
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom % 100;
      logic [31:0] t = $urandom;
      if (r < 3)       cyc(1, 41, $urandom % 4, $urandom % 2, t, "RND R8 R10 cfg");
      else if (r < 10) cyc(1, $urandom % 43, $urandom % 256, $urandom % 2, t, "RND R9 write");
      else if (r < 75) smp(t, "RND R4 R6 strobe");
      else             cyc(0, 0, 0, 0, t, "RND R7 idle");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule